// File: doc/BRIEF.md
# Byte-Wide CPU Bridge with Interleaved Refresh

This block connects an 8-bit CPU to a fixed-latency 16-bit SDRAM controller. The controller takes a level request for an access, an active-low write enable and a refresh request. It answers with a ready level after its own start-up and a one-cycle done pulse when each operation ends. After reset the bridge waits for ready. It then turns each single-cycle CPU access strobe into a controller access and picks the byte lane from the lowest CPU address bit. On a read it returns the selected byte to the CPU.

Every CPU access is followed at once by one refresh operation, so a refresh never sits in front of a CPU access. When the CPU stays quiet, a gap counter inserts a standalone refresh. This keeps the refresh interval bounded with no CPU traffic at all. A busy output tells the CPU when an access is still in progress. One strobe that arrives during busy is held in a pending slot and served next.

Top module: `byteRefreshBridge`

## Requirements
- R1: No access or refresh request is raised before `memReady` has been seen high. A strobe that arrives before then is held and served once the controller is ready.
- R2: For a read, `memRw` stays high from its first cycle until the cycle in which `memDone` is high, and it is low in that done cycle. `memWeN` stays 1 for the whole request.
- R3: For a write, `memRw` is high and `memWeN` is 0 together in every request cycle until `memDone`.
- R4: In the cycle after an access's done cycle, `memRefresh` goes high. It stays high until its own done cycle and then drops. `memRw` and `memRefresh` are never high together.
- R5: The read byte is taken from `memRdData` in the done cycle: bits 15:8 when CPU address bit 0 is 1, bits 7:0 when it is 0. `cpuRdValid` pulses for one cycle in the next cycle, and `cpuRdData` holds the byte afterwards.
- R6: On a write, CPU address bit 0 = 0 drives `memLbN`=0 and `memUbN`=1, and bit 0 = 1 drives `memUbN`=0 and `memLbN`=1. On a read both enables are 0. A write to one byte leaves the other byte of the same word unchanged.
- R7: On a write, `memWrData` carries the CPU byte in both halves.
- R8: `memAddr` equals CPU address bits 15:1 in its low 15 bits, and all of its higher bits are 0.
- R9: `busy` is high from the cycle after an accepted strobe until the refresh that follows that access has finished. A strobe during busy is served after the current access and is never dropped. A standalone refresh alone does not raise `busy`.
- R10: With no CPU access, a standalone refresh request rises REFRESH_GAP+2 cycles after the previous refresh's done cycle, or after the first cycle with `memReady` high.
- R11: If a pending access and a due standalone refresh meet in the same idle cycle, the access goes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpuStb | input | 1 | Single-cycle CPU access strobe |
| cpuWr | input | 1 | 1 = write, 0 = read; sampled with `cpuStb` |
| cpuAddr | input | 16 | CPU byte address; sampled with `cpuStb` |
| cpuWrData | input | 8 | CPU write byte; sampled with `cpuStb` |
| cpuRdData | output | 8 | Last byte read |
| cpuRdValid | output | 1 | One-cycle pulse when `cpuRdData` is new |
| busy | output | 1 | An accepted access and its refresh are not yet finished |
| memReady | input | 1 | Controller start-up complete |
| memDone | input | 1 | One-cycle completion pulse from the controller |
| memRdData | input | 16 | Controller read word, valid in the done cycle |
| memRw | output | 1 | Access request, active high |
| memWeN | output | 1 | Write enable, active low |
| memRefresh | output | 1 | Refresh request, active high |
| memAddr | output | 24 | Controller word address |
| memWrData | output | 16 | Controller write word |
| memUbN | output | 1 | Upper byte enable, active low |
| memLbN | output | 1 | Lower byte enable, active low |

## Verification
The properties take three things for granted about the environment. The controller raises `memDone` for exactly one cycle, and only while one of the two requests is held. `memReady` does not fall once it has risen. The CPU issues at most one further strobe while `busy` is high. The bench's controller model gives every request a single done pulse after a fixed latency and holds ready high after start-up. Its CPU driver waits for `busy` to clear before each new strobe, except for one overlapped strobe that tests the pending slot.

// File: rtl/bridge_pkg.sv
`timescale 1ns/1ps
package bridge_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_RDY = 2'd0,
    ST_IDLE     = 2'd1,
    ST_ACCESS   = 2'd2,
    ST_REFRESH  = 2'd3
  } bridgeState_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic takePend;   // move the pending slot into the current-access register
    logic captureRd;  // latch the selected read byte this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/bridge_ctrl.sv
`timescale 1ns/1ps
module bridge_ctrl
  import bridge_pkg::*;
#(
  parameter int REFRESH_GAP = 600
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        memReady,
  input  logic        memDone,
  input  logic        pendValid,
  input  logic        curWr,
  output ctrlStrobe_t strobes,
  output logic        memRw,
  output logic        memRefresh,
  output logic        memWeN,
  output logic        busy
);

  localparam int GAP_W = $clog2(REFRESH_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(REFRESH_GAP);

  bridgeState_e state, stateNext;
  logic refAfterAccess, refAfterNext;
  logic [GAP_W-1:0] gapCnt;
  logic gapDue;

  assign gapDue = (gapCnt == GAP_MAX);

  always_comb begin
    stateNext    = state;
    refAfterNext = refAfterAccess;
    unique case (state)
      ST_WAIT_RDY: if (memReady) stateNext = ST_IDLE;
      ST_IDLE: begin
        if (pendValid) begin
          stateNext = ST_ACCESS;
        end else if (gapDue) begin
          stateNext    = ST_REFRESH;
          refAfterNext = 1'b0;
        end
      end
      ST_ACCESS: begin
        if (memDone) begin
          stateNext    = ST_REFRESH;
          refAfterNext = 1'b1;
        end
      end
      ST_REFRESH: if (memDone) stateNext = ST_IDLE;
      default: stateNext = ST_WAIT_RDY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= ST_WAIT_RDY;
      refAfterAccess <= 1'b0;
    end else begin
      state          <= stateNext;
      refAfterAccess <= refAfterNext;
    end
  end

  // Cycles since the last refresh finished; held at zero before ready.
  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt <= '0;
    end else if (state == ST_WAIT_RDY || (state == ST_REFRESH && memDone)) begin
      gapCnt <= '0;
    end else if (!gapDue) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  // Requests drop in the done cycle itself.
  assign memRw      = (state == ST_ACCESS)  && !memDone;
  assign memRefresh = (state == ST_REFRESH) && !memDone;
  assign memWeN     = !((state == ST_ACCESS) && curWr);

  assign strobes.takePend  = (state == ST_IDLE) && pendValid;
  assign strobes.captureRd = (state == ST_ACCESS) && memDone && !curWr;

  assign busy = pendValid || (state == ST_ACCESS) ||
                ((state == ST_REFRESH) && refAfterAccess);

endmodule

// File: rtl/bridge_dpath.sv
`timescale 1ns/1ps
module bridge_dpath
  import bridge_pkg::*;
#(
  parameter int CPU_AW = 16,
  parameter int BYTE_W = 8,
  parameter int MEM_AW = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpuStb,
  input  logic                cpuWr,
  input  logic [CPU_AW-1:0]   cpuAddr,
  input  logic [BYTE_W-1:0]   cpuWrData,
  input  ctrlStrobe_t         strobes,
  input  logic [2*BYTE_W-1:0] memRdData,
  output logic                pendValid,
  output logic                curWr,
  output logic [MEM_AW-1:0]   memAddr,
  output logic [2*BYTE_W-1:0] memWrData,
  output logic                memUbN,
  output logic                memLbN,
  output logic [BYTE_W-1:0]   cpuRdData,
  output logic                cpuRdValid
);

  localparam int WORD_AW = CPU_AW - 1;
  localparam int PAD_W   = MEM_AW - WORD_AW;

  logic              pendWr;
  logic [CPU_AW-1:0] pendAddr;
  logic [BYTE_W-1:0] pendData;
  logic [CPU_AW-1:0] curAddr;
  logic [BYTE_W-1:0] curData;
  logic              laneHi;

  // One-deep pending slot; a new strobe wins over a same-cycle take.
  always_ff @(posedge clk) begin
    if (rst) begin
      pendValid <= 1'b0;
    end else if (cpuStb) begin
      pendValid <= 1'b1;
    end else if (strobes.takePend) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (cpuStb) begin
      pendWr   <= cpuWr;
      pendAddr <= cpuAddr;
      pendData <= cpuWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curWr   <= 1'b0;
      curAddr <= '0;
      curData <= '0;
    end else if (strobes.takePend) begin
      curWr   <= pendWr;
      curAddr <= pendAddr;
      curData <= pendData;
    end
  end

  assign laneHi = curAddr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cpuRdData  <= '0;
      cpuRdValid <= 1'b0;
    end else begin
      cpuRdValid <= strobes.captureRd;
      if (strobes.captureRd) begin
        cpuRdData <= memRdData[laneHi*BYTE_W +: BYTE_W];
      end
    end
  end

  assign memAddr   = {{PAD_W{1'b0}}, curAddr[CPU_AW-1:1]};
  assign memWrData = {2{curData}};
  assign memUbN    = curWr ? !laneHi : 1'b0;
  assign memLbN    = curWr ?  laneHi : 1'b0;

endmodule

// File: rtl/byteRefreshBridge.sv
`timescale 1ns/1ps
module byteRefreshBridge
  import bridge_pkg::*;
#(
  parameter int CPU_AW      = 16,
  parameter int BYTE_W      = 8,
  parameter int MEM_AW      = 24,
  parameter int REFRESH_GAP = 600
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpuStb,
  input  logic                cpuWr,
  input  logic [CPU_AW-1:0]   cpuAddr,
  input  logic [BYTE_W-1:0]   cpuWrData,
  output logic [BYTE_W-1:0]   cpuRdData,
  output logic                cpuRdValid,
  output logic                busy,
  input  logic                memReady,
  input  logic                memDone,
  input  logic [2*BYTE_W-1:0] memRdData,
  output logic                memRw,
  output logic                memWeN,
  output logic                memRefresh,
  output logic [MEM_AW-1:0]   memAddr,
  output logic [2*BYTE_W-1:0] memWrData,
  output logic                memUbN,
  output logic                memLbN
);

  ctrlStrobe_t strobes;
  logic pendValid;
  logic curWr;

  bridge_ctrl #(
    .REFRESH_GAP(REFRESH_GAP)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .memReady  (memReady),
    .memDone   (memDone),
    .pendValid (pendValid),
    .curWr     (curWr),
    .strobes   (strobes),
    .memRw     (memRw),
    .memRefresh(memRefresh),
    .memWeN    (memWeN),
    .busy      (busy)
  );

  bridge_dpath #(
    .CPU_AW(CPU_AW),
    .BYTE_W(BYTE_W),
    .MEM_AW(MEM_AW)
  ) dpath_i (
    .clk       (clk),
    .rst       (rst),
    .cpuStb    (cpuStb),
    .cpuWr     (cpuWr),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .strobes   (strobes),
    .memRdData (memRdData),
    .pendValid (pendValid),
    .curWr     (curWr),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .memUbN    (memUbN),
    .memLbN    (memLbN),
    .cpuRdData (cpuRdData),
    .cpuRdValid(cpuRdValid)
  );

endmodule

// File: rtl/bridge_checker.sv
`timescale 1ns/1ps
module bridge_checker #(
  parameter int CPU_AW      = 16,
  parameter int BYTE_W      = 8,
  parameter int MEM_AW      = 24,
  parameter int REFRESH_GAP = 600
) (
  input logic                clk,
  input logic                rst,
  input logic                memReady,
  input logic                memDone,
  input logic                memRw,
  input logic                memRefresh,
  input logic                memWeN,
  input logic                memUbN,
  input logic                memLbN,
  input logic [MEM_AW-1:0]   memAddr,
  input logic [2*BYTE_W-1:0] memWrData,
  input logic                busy,
  input logic                cpuRdValid
);

  localparam int WORD_AW  = CPU_AW - 1;
  localparam int RUN_MAX  = REFRESH_GAP + 2;

  logic readySeen;
  int unsigned idleRun;

  always_ff @(posedge clk) begin
    if (rst) begin
      readySeen <= 1'b0;
      idleRun   <= 0;
    end else begin
      if (memReady) readySeen <= 1'b1;
      if (readySeen && !memRw && !memRefresh) idleRun <= idleRun + 1;
      else idleRun <= 0;
    end
  end

  AST_NO_REQ_BEFORE_READY: assert property (@(posedge clk) disable iff (rst)
    (memRw || memRefresh) |-> readySeen); // R1
  AST_RW_HELD: assert property (@(posedge clk) disable iff (rst)
    memRw |=> (memRw || memDone)); // R2
  AST_WE_STABLE: assert property (@(posedge clk) disable iff (rst)
    memRw |=> (!memRw || $stable(memWeN))); // R3
  AST_REF_AFTER_ACCESS: assert property (@(posedge clk) disable iff (rst)
    $fell(memRw) |=> memRefresh); // R4
  AST_REF_HELD: assert property (@(posedge clk) disable iff (rst)
    memRefresh |=> (memRefresh || memDone)); // R4
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(memRw && memRefresh)); // R4
  AST_RDVALID_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    cpuRdValid |-> $past(memDone)); // R5
  AST_ONE_LANE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (memRw && !memWeN) |-> (memUbN != memLbN)); // R6
  AST_BOTH_LANES_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (memRw && memWeN) |-> (!memUbN && !memLbN)); // R6
  AST_WDATA_REPLICATED: assert property (@(posedge clk) disable iff (rst)
    (memRw && !memWeN) |-> (memWrData[2*BYTE_W-1:BYTE_W] == memWrData[BYTE_W-1:0])); // R7
  AST_ADDR_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    memRw |-> ((memAddr >> WORD_AW) == '0)); // R8
  AST_BUSY_DURING_ACCESS: assert property (@(posedge clk) disable iff (rst)
    memRw |-> busy); // R9
  AST_REFRESH_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    idleRun <= RUN_MAX); // R10

endmodule

bind byteRefreshBridge bridge_checker #(
  .CPU_AW(CPU_AW),
  .BYTE_W(BYTE_W),
  .MEM_AW(MEM_AW),
  .REFRESH_GAP(REFRESH_GAP)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .memReady  (memReady),
  .memDone   (memDone),
  .memRw     (memRw),
  .memRefresh(memRefresh),
  .memWeN    (memWeN),
  .memUbN    (memUbN),
  .memLbN    (memLbN),
  .memAddr   (memAddr),
  .memWrData (memWrData),
  .busy      (busy),
  .cpuRdValid(cpuRdValid)
);

// File: tb/byteRefreshBridge_tb.sv
`timescale 1ns/1ps
module byteRefreshBridge_tb_top;

  localparam int CPU_AW      = 16;
  localparam int BYTE_W      = 8;
  localparam int MEM_AW      = 24;
  localparam int REFRESH_GAP = 600;
  localparam int INIT_CYC    = 30;
  localparam int ACC_LAT     = 6;
  localparam int REF_LAT     = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;  // 200 MHz

  logic        cpuStb, cpuWr;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuWrData, cpuRdData;
  logic        cpuRdValid, busy;
  logic        memReady, memDone;
  logic [15:0] memRdData;
  logic        memRw, memWeN, memRefresh;
  logic [23:0] memAddr;
  logic [15:0] memWrData;
  logic        memUbN, memLbN;

  byteRefreshBridge #(
    .CPU_AW(CPU_AW), .BYTE_W(BYTE_W), .MEM_AW(MEM_AW), .REFRESH_GAP(REFRESH_GAP)
  ) dut_i (
    .clk(clk), .rst(rst), .cpuStb(cpuStb), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .cpuRdValid(cpuRdValid), .busy(busy),
    .memReady(memReady), .memDone(memDone), .memRdData(memRdData), .memRw(memRw),
    .memWeN(memWeN), .memRefresh(memRefresh), .memAddr(memAddr), .memWrData(memWrData),
    .memUbN(memUbN), .memLbN(memLbN)
  );

  int testCnt = 0;
  int failCnt = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- controller model ----------------
  int          initCnt, ctlCnt, ctlSt;
  logic        ctlWr, ctlUbN, ctlLbN;
  logic [23:0] ctlAddr;
  logic [15:0] ctlWd, word;
  logic [15:0] wordMem [int];

  always @(posedge clk) begin
    if (rst) begin
      memReady <= 1'b0; memDone <= 1'b0; memRdData <= 16'hDEAD;
      initCnt <= 0; ctlSt <= 0; ctlCnt <= 0;
    end else begin
      memDone   <= 1'b0;
      memRdData <= 16'hDEAD;
      if (!memReady) begin
        initCnt <= initCnt + 1;
        if (initCnt == INIT_CYC - 1) memReady <= 1'b1;
      end else begin
        case (ctlSt)
          0: begin
            if (memRw) begin
              ctlSt <= 1; ctlCnt <= ACC_LAT; ctlWr <= !memWeN; ctlAddr <= memAddr;
              ctlWd <= memWrData; ctlUbN <= memUbN; ctlLbN <= memLbN;
            end else if (memRefresh) begin
              ctlSt <= 2; ctlCnt <= REF_LAT;
            end
          end
          1, 2: begin
            if (ctlCnt == 1) begin
              memDone <= 1'b1;
              if (ctlSt == 1) begin
                word = wordMem.exists(int'(ctlAddr)) ? wordMem[int'(ctlAddr)] : 16'h0000;
                if (ctlWr) begin
                  if (!ctlUbN) word[15:8] = ctlWd[15:8];
                  if (!ctlLbN) word[7:0]  = ctlWd[7:0];
                  wordMem[int'(ctlAddr)] = word;
                end else begin
                  memRdData <= word;
                end
              end
              ctlSt <= 3;
            end else begin
              ctlCnt <= ctlCnt - 1;
            end
          end
          default: ctlSt <= 0;
        endcase
      end
    end
  end

  // ---------------- reference model ----------------
  typedef struct { bit wr; logic [15:0] addr; logic [7:0] data; } acc_t;
  acc_t pendQ[$];
  acc_t mCur;
  int   mPhase, oldPhase, mGap;
  bit   mRefAfter, mRdValid;
  logic [7:0] mRdData;

  always @(posedge clk) begin
    if (rst) begin
      pendQ.delete(); mPhase = 0; mGap = 0; mRefAfter = 0; mRdValid = 0; mRdData = 0;
      mCur = '{0, 16'h0, 8'h0};
    end else begin
      oldPhase = mPhase;
      mRdValid = 0;
      case (mPhase)
        0: if (memReady) mPhase = 1;
        1: begin
          if (pendQ.size() > 0) begin mCur = pendQ.pop_front(); mPhase = 2; end
          else if (mGap >= REFRESH_GAP) begin mPhase = 3; mRefAfter = 0; end
        end
        2: if (memDone) begin
          mPhase = 3; mRefAfter = 1;
          if (!mCur.wr) begin
            mRdValid = 1;
            mRdData = mCur.addr[0] ? memRdData[15:8] : memRdData[7:0];
          end
        end
        default: if (memDone) mPhase = 1;
      endcase
      if (oldPhase == 0 || (oldPhase == 3 && memDone)) mGap = 0;
      else if (mGap < REFRESH_GAP) mGap++;
      if (cpuStb) pendQ.push_back('{cpuWr, cpuAddr, cpuWrData});
    end
  end

  // ---------------- per-cycle comparison and monitors ----------------
  bit   expRw, expRef, expBusy;
  int   earlyReq = 0;
  int   refRises = 0;
  int   busyCycles = 0;
  logic prevRef = 1'b0;
  logic [7:0] lastRd = 8'h00;

  always @(negedge clk) begin
    if (!rst) begin
      expRw   = (mPhase == 2) && !memDone;
      expRef  = (mPhase == 3) && !memDone;
      expBusy = (pendQ.size() > 0) || (mPhase == 2) || (mPhase == 3 && mRefAfter);
      chk("R2", "memRw", memRw, expRw);
      chk("R4", "memRefresh", memRefresh, expRef);
      chk("R9", "busy", busy, expBusy);
      chk("R5", "cpuRdValid", cpuRdValid, mRdValid);
      if (expRw) begin
        chk("R3", "memWeN", memWeN, !mCur.wr);
        chk("R8", "memAddr", memAddr, {9'b0, mCur.addr[15:1]});
        if (mCur.wr) begin
          chk("R7", "memWrData", memWrData, {mCur.data, mCur.data});
          chk("R6", "memUbN write", memUbN, !mCur.addr[0]);
          chk("R6", "memLbN write", memLbN, mCur.addr[0]);
        end else begin
          chk("R6", "memUbN read", memUbN, 1'b0);
          chk("R6", "memLbN read", memLbN, 1'b0);
        end
      end
      if (mRdValid) chk("R5", "cpuRdData", cpuRdData, mRdData);
      if (!memReady && (memRw || memRefresh)) earlyReq++;
      if (memRefresh && !prevRef) refRises++;
      if (busy) busyCycles++;
      if (cpuRdValid) lastRd = cpuRdData;
      prevRef = memRefresh;
    end
  end

  // ---------------- CPU driver ----------------
  logic [7:0] expMem [int];

  task automatic issue(input bit wr, input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpuStb = 1'b1; cpuWr = wr; cpuAddr = a; cpuWrData = d;
    @(posedge clk); #1;
    cpuStb = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busy);
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [7:0] d);
    issue(1'b1, a, d);
    waitIdle();
    expMem[int'(a)] = d;
  endtask

  task automatic doRead(input logic [15:0] a, input string req);
    logic [7:0] e;
    issue(1'b0, a, 8'h00);
    waitIdle();
    e = expMem.exists(int'(a)) ? expMem[int'(a)] : 8'h00;
    chk(req, "read-back byte", lastRd, e);
  endtask

  initial begin
    int rises0, busy0;
    bit sawRw;
    cpuStb = 1'b0; cpuWr = 1'b0; cpuAddr = '0; cpuWrData = '0;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R9", "busy after reset", busy, 1'b0);
    chk("R2", "memRw after reset", memRw, 1'b0);
    chk("R4", "memRefresh after reset", memRefresh, 1'b0);
    chk("R5", "cpuRdValid after reset", cpuRdValid, 1'b0);
    chk("R1", "controller not ready yet", memReady, 1'b0);

    // R1: strobe before ready is held, then served
    doWrite(16'h0010, 8'hA5);
    chk("R1", "requests before ready", earlyReq, 0);

    doWrite(16'h0011, 8'h3C);
    doWrite(16'h1235, 8'h7E);
    doWrite(16'hFFFE, 8'h11);
    doWrite(16'hFFFF, 8'h22);
    doWrite(16'h0000, 8'h99);

    doRead(16'h0010, "R5");
    doRead(16'h0011, "R6");
    doRead(16'h1235, "R5");
    doRead(16'hFFFE, "R8");
    doRead(16'hFFFF, "R8");
    doRead(16'h0000, "R7");
    doRead(16'h4444, "R5");

    // R6: rewriting the low byte keeps the high byte of the same word
    doWrite(16'h0010, 8'h5A);
    doRead(16'h0011, "R6");
    doRead(16'h0010, "R6");

    // R9: second strobe while busy is held and served
    issue(1'b1, 16'h2000, 8'hC3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", "busy before overlapped strobe", busy, 1'b1);
    issue(1'b0, 16'h2000, 8'h00);
    waitIdle();
    expMem[int'(16'h2000)] = 8'hC3;
    chk("R9", "overlapped read result", lastRd, 8'hC3);

    // R10: standalone refresh while idle, busy stays low
    rises0 = refRises; busy0 = busyCycles;
    repeat (2 * REFRESH_GAP + 40) @(negedge clk);
    chk("R10", "standalone refresh seen", (refRises - rises0) >= 2, 1'b1);
    chk("R9", "busy during standalone refresh", busyCycles - busy0, 0);

    // R11: access pending exactly when the gap expires goes first
    do @(negedge clk); while (!memDone);
    repeat (REFRESH_GAP) @(posedge clk);
    #1 cpuStb = 1'b1; cpuWr = 1'b0; cpuAddr = 16'h1235;
    @(posedge clk); #1 cpuStb = 1'b0;
    do @(negedge clk); while (!memRw && !memRefresh);
    sawRw = memRw;
    chk("R11", "access before due refresh", sawRw, 1'b1);
    waitIdle();
    chk("R11", "read after priority case", lastRd, 8'h7E);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule